// File: doc/BRIEF.md
# Host I/O Port Mailbox Channel

This block is one byte-wide mailbox between a host I/O bus and a local controller, shaped like a legacy keyboard-controller or embedded-controller port pair. The host sees two byte addresses. The lower one is the data port. The one a fixed gap above it is the command port. A host write to either port lands in a single input byte, and a flag records which port it hit. A host read of the data port returns the byte the controller last posted. A host read of the command port returns a status byte.

The controller reads the input byte, posts an output byte and can mark itself busy. While it is busy, a new command from the host is dropped rather than allowed to overwrite the one being handled. One-cycle strobes tell the controller when a write was accepted, when one was dropped and when the host has taken the posted byte. A build parameter makes the channel command-only, so that host writes to the data port are always dropped.

Top module: `host_mailbox_chan`

## Requirements
- R1: Synchronous reset clears in_full, out_full, busy, the command flag, the input byte, the output byte, host_rdata and all three strobes.
- R2: A host write to DATA_PORT or to DATA_PORT+PORT_GAP that is accepted stores host_wdata in loc_in_byte and sets loc_in_full. It sets loc_is_cmd to 1 for the command port and to 0 for the data port. It pulses ev_host_wr for one cycle. All of this is visible on the clock edge that samples the write.
- R3: loc_rd_in clears loc_in_full on the next edge. An accepted host write in the same cycle wins and leaves it set.
- R4: loc_wr_out loads loc_out_data into the output byte and sets loc_out_full.
- R5: A host read of the data port loads the output byte into host_rdata, clears loc_out_full and pulses ev_host_rd for one cycle. A loc_wr_out in the same cycle wins and leaves loc_out_full set.
- R6: A host read of the command port loads host_rdata with a status byte. Bit 0 is out_full, bit 1 is in_full, bit 2 is busy and bit 3 is the command flag. Bits 7:4 are zero, and bit 4 is the burst flag, which always reads 0. Every flag is taken as it stood before that edge.
- R7: loc_set_busy sets loc_busy and loc_clr_busy clears it. If both are high in the same cycle, set wins.
- R8: A host write to the command port while loc_busy is high is dropped. loc_in_byte and loc_is_cmd keep their values, loc_in_full is cleared and ev_drop pulses for one cycle. Data-port writes while busy are accepted.
- R9: With CMD_CHANNEL=1, every host write to the data port is dropped in the same way as R8, whatever the busy state.
- R10: Host reads and writes to any other address change no state, no strobe and not host_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host I/O address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | DW | Host write byte |
| host_rdata | output | DW | Registered host read byte |
| loc_rd_in | input | 1 | Controller has consumed the input byte |
| loc_in_byte | output | DW | Last accepted host byte |
| loc_is_cmd | output | 1 | Last accepted byte came through the command port |
| loc_in_full | output | 1 | Input byte pending |
| loc_wr_out | input | 1 | Controller posts an output byte |
| loc_out_data | input | DW | Output byte to post |
| loc_out_full | output | 1 | Output byte pending for the host |
| loc_set_busy | input | 1 | Set busy flag |
| loc_clr_busy | input | 1 | Clear busy flag |
| loc_busy | output | 1 | Busy flag |
| ev_host_wr | output | 1 | One-cycle pulse per accepted host write |
| ev_host_rd | output | 1 | One-cycle pulse per host data-port read |
| ev_drop | output | 1 | One-cycle pulse per dropped host write |

## Verification
Every flag lives in a register that drives a port, and the status byte repeats those flags to the host. A wrong flag therefore shows at the ports on the first edge after the event that corrupts it, and it shows again in the next status read. Example faults are a lost in_full, a command flag taken from the wrong port, or a busy drop that lets the byte through. The trickier defects are priority slips between a local action and a host action in the same cycle, and ordering slips between the status snapshot and the flag update. Random stimulus that often collides local and host strobes exposes these within a few cycles, because the bench compares every output on every cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Status byte bit positions seen by the host
  localparam int ST_OUT_FULL = 0;
  localparam int ST_IN_FULL  = 1;
  localparam int ST_BUSY     = 2;
  localparam int ST_CMD      = 3;
  localparam int ST_BURST    = 4;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_DATA = 2'd1,
    HIT_CMD  = 2'd2
  } port_hit_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0062,
  parameter int PORT_GAP = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output mbx_pkg::port_hit_e hit
);
  localparam logic [ADDR_W-1:0] CMD_PORT = DATA_PORT + ADDR_W'(PORT_GAP);

  always_comb begin
    if (addr == DATA_PORT)     hit = mbx_pkg::HIT_DATA;
    else if (addr == CMD_PORT) hit = mbx_pkg::HIT_CMD;
    else                       hit = mbx_pkg::HIT_NONE;
  end
endmodule

// File: rtl/mbx_inreg.sv
module mbx_inreg #(
  parameter int DW = 8,
  parameter bit CMD_CHANNEL = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_is_cmd,
  input  logic [DW-1:0] wr_data,
  input  logic          busy,
  input  logic          loc_rd,
  output logic [DW-1:0] in_byte,
  output logic          in_full,
  output logic          is_cmd,
  output logic          ev_wr,
  output logic          ev_drop
);
  logic accept;

  generate
    if (CMD_CHANNEL) begin : g_cmd_only
      assign accept = wr_en && wr_is_cmd && !busy;
    end else begin : g_shared
      assign accept = wr_en && !(wr_is_cmd && busy);
    end
  endgenerate

  wire drop = wr_en && !accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_byte <= '0;
      in_full <= 1'b0;
      is_cmd  <= 1'b0;
      ev_wr   <= 1'b0;
      ev_drop <= 1'b0;
    end else begin
      ev_wr   <= accept;
      ev_drop <= drop;
      if (accept) begin
        in_byte <= wr_data;
        is_cmd  <= wr_is_cmd;
        in_full <= 1'b1;
      end else if (drop || loc_rd) begin
        in_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mbx_outreg.sv
module mbx_outreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          loc_wr,
  input  logic [DW-1:0] loc_data,
  input  logic          host_take,
  output logic [DW-1:0] out_byte,
  output logic          out_full,
  output logic          ev_rd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_byte <= '0;
      out_full <= 1'b0;
      ev_rd    <= 1'b0;
    end else begin
      ev_rd <= host_take;
      if (loc_wr) begin
        out_byte <= loc_data;
        out_full <= 1'b1;
      end else if (host_take) begin
        out_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/host_mailbox_chan.sv
module host_mailbox_chan #(
  parameter int ADDR_W = 16,
  parameter int DW = 8,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0062,
  parameter int PORT_GAP = 4,
  parameter bit CMD_CHANNEL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  input  logic              loc_rd_in,
  output logic [DW-1:0]     loc_in_byte,
  output logic              loc_is_cmd,
  output logic              loc_in_full,
  input  logic              loc_wr_out,
  input  logic [DW-1:0]     loc_out_data,
  output logic              loc_out_full,
  input  logic              loc_set_busy,
  input  logic              loc_clr_busy,
  output logic              loc_busy,
  output logic              ev_host_wr,
  output logic              ev_host_rd,
  output logic              ev_drop
);
  mbx_pkg::port_hit_e hit;
  logic [DW-1:0] out_byte;
  logic [DW-1:0] status;

  mbx_decode #(.ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT), .PORT_GAP(PORT_GAP)) u_dec (
    .addr(host_addr), .hit(hit)
  );

  wire wr_hit   = host_wr && (hit != mbx_pkg::HIT_NONE);
  wire rd_data  = host_rd && (hit == mbx_pkg::HIT_DATA);
  wire rd_stat  = host_rd && (hit == mbx_pkg::HIT_CMD);

  mbx_inreg #(.DW(DW), .CMD_CHANNEL(CMD_CHANNEL)) u_in (
    .clk(clk), .rst(rst),
    .wr_en(wr_hit), .wr_is_cmd(hit == mbx_pkg::HIT_CMD), .wr_data(host_wdata),
    .busy(loc_busy), .loc_rd(loc_rd_in),
    .in_byte(loc_in_byte), .in_full(loc_in_full), .is_cmd(loc_is_cmd),
    .ev_wr(ev_host_wr), .ev_drop(ev_drop)
  );

  mbx_outreg #(.DW(DW)) u_out (
    .clk(clk), .rst(rst),
    .loc_wr(loc_wr_out), .loc_data(loc_out_data), .host_take(rd_data),
    .out_byte(out_byte), .out_full(loc_out_full), .ev_rd(ev_host_rd)
  );

  always_comb begin
    status = '0;
    status[mbx_pkg::ST_OUT_FULL] = loc_out_full;
    status[mbx_pkg::ST_IN_FULL]  = loc_in_full;
    status[mbx_pkg::ST_BUSY]     = loc_busy;
    status[mbx_pkg::ST_CMD]      = loc_is_cmd;
    status[mbx_pkg::ST_BURST]    = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_busy   <= 1'b0;
      host_rdata <= '0;
    end else begin
      if (loc_set_busy)      loc_busy <= 1'b1;
      else if (loc_clr_busy) loc_busy <= 1'b0;
      if (rd_data)           host_rdata <= out_byte;
      else if (rd_stat)      host_rdata <= status;
    end
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int ADDR_W = 16,
  parameter int DW = 8,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0062,
  parameter int PORT_GAP = 4,
  parameter bit CMD_CHANNEL = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic [DW-1:0]     host_rdata,
  input logic              loc_rd_in,
  input logic [DW-1:0]     loc_in_byte,
  input logic              loc_is_cmd,
  input logic              loc_in_full,
  input logic              loc_wr_out,
  input logic              loc_out_full,
  input logic              loc_set_busy,
  input logic              loc_busy,
  input logic              ev_host_wr,
  input logic              ev_drop
);
  localparam logic [ADDR_W-1:0] CMD_PORT = DATA_PORT + ADDR_W'(PORT_GAP);

  assert_cmd_accept_R2: assert property (@(posedge clk) disable iff (rst)
    host_wr && host_addr == CMD_PORT && !loc_busy |=> loc_in_full && loc_is_cmd && ev_host_wr);

  assert_local_read_R3: assert property (@(posedge clk) disable iff (rst)
    loc_rd_in && !host_wr |=> !loc_in_full);

  assert_local_write_R4: assert property (@(posedge clk) disable iff (rst)
    loc_wr_out |=> loc_out_full);

  assert_status_flags_R6: assert property (@(posedge clk) disable iff (rst)
    host_rd && host_addr == CMD_PORT |=>
      host_rdata[4] == 1'b0 && host_rdata[1] == $past(loc_in_full) && host_rdata[2] == $past(loc_busy));

  assert_busy_set_R7: assert property (@(posedge clk) disable iff (rst)
    loc_set_busy |=> loc_busy);

  assert_busy_drop_R8: assert property (@(posedge clk) disable iff (rst)
    host_wr && host_addr == CMD_PORT && loc_busy |=> !loc_in_full && $stable(loc_in_byte) && ev_drop && !ev_host_wr);
endmodule

bind host_mailbox_chan mbx_checker #(
  .ADDR_W(ADDR_W), .DW(DW), .DATA_PORT(DATA_PORT), .PORT_GAP(PORT_GAP), .CMD_CHANNEL(CMD_CHANNEL)
) u_chk (.*);

// File: tb/test_host_mailbox_chan.sv
module test_host_mailbox_chan;
  localparam logic [15:0] DP = 16'h0062;
  localparam logic [15:0] CP = 16'h0066;
  localparam logic [15:0] XP = 16'h0063;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] host_addr = '0;
  logic host_wr = 0, host_rd = 0, loc_rd_in = 0, loc_wr_out = 0, loc_set_busy = 0, loc_clr_busy = 0;
  logic [7:0] host_wdata = '0, loc_out_data = '0;
  logic [7:0] host_rdata, loc_in_byte;
  logic loc_is_cmd, loc_in_full, loc_out_full, loc_busy, ev_host_wr, ev_host_rd, ev_drop;
  logic [7:0] c_rdata, c_in_byte;
  logic c_is_cmd, c_in_full, c_out_full, c_busy, c_ev_wr, c_ev_rd, c_ev_drop;

  always #2 clk = ~clk;

  host_mailbox_chan i_host_mailbox_chan (
    .clk, .rst, .host_addr, .host_wr, .host_rd, .host_wdata, .host_rdata,
    .loc_rd_in, .loc_in_byte, .loc_is_cmd, .loc_in_full, .loc_wr_out, .loc_out_data,
    .loc_out_full, .loc_set_busy, .loc_clr_busy, .loc_busy, .ev_host_wr, .ev_host_rd, .ev_drop
  );

  host_mailbox_chan #(.CMD_CHANNEL(1'b1)) i_cmd_only (
    .clk, .rst, .host_addr, .host_wr, .host_rd, .host_wdata, .host_rdata(c_rdata),
    .loc_rd_in, .loc_in_byte(c_in_byte), .loc_is_cmd(c_is_cmd), .loc_in_full(c_in_full),
    .loc_wr_out, .loc_out_data, .loc_out_full(c_out_full), .loc_set_busy, .loc_clr_busy,
    .loc_busy(c_busy), .ev_host_wr(c_ev_wr), .ev_host_rd(c_ev_rd), .ev_drop(c_ev_drop)
  );

  int checks = 0, errors = 0;
  logic [7:0] m_in, m_out, m_rdata;
  logic m_ibf, m_obf, m_busy, m_cmd, m_evw, m_evr, m_evd;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] stat_byte(logic obf, logic ibf, logic bsy, logic cmd);
    return {4'b0000, cmd, bsy, ibf, obf};
  endfunction

  task automatic model_reset();
    m_in = 0; m_out = 0; m_rdata = 0; m_ibf = 0; m_obf = 0; m_busy = 0; m_cmd = 0;
    m_evw = 0; m_evr = 0; m_evd = 0;
  endtask

  task automatic model_step();
    logic hd, hc, acc, drp, rdd, rdc;
    logic [7:0] st;
    hd = host_wr && host_addr == DP;
    hc = host_wr && host_addr == CP;
    acc = (hd || hc) && !(hc && m_busy);
    drp = (hd || hc) && !acc;
    rdd = host_rd && host_addr == DP;
    rdc = host_rd && host_addr == CP;
    st = stat_byte(m_obf, m_ibf, m_busy, m_cmd);
    if (rdd) m_rdata = m_out; else if (rdc) m_rdata = st;
    if (acc) begin m_in = host_wdata; m_cmd = hc; m_ibf = 1; end
    else if (drp || loc_rd_in) m_ibf = 0;
    if (loc_wr_out) begin m_out = loc_out_data; m_obf = 1; end
    else if (rdd) m_obf = 0;
    if (loc_set_busy) m_busy = 1; else if (loc_clr_busy) m_busy = 0;
    m_evw = acc; m_evd = drp; m_evr = rdd;
  endtask

  task automatic cmp_all(string tag);
    chk({tag, " in_byte"}, loc_in_byte, m_in);
    chk({tag, " in_full"}, {7'd0, loc_in_full}, {7'd0, m_ibf});
    chk({tag, " is_cmd"}, {7'd0, loc_is_cmd}, {7'd0, m_cmd});
    chk({tag, " out_full"}, {7'd0, loc_out_full}, {7'd0, m_obf});
    chk({tag, " busy"}, {7'd0, loc_busy}, {7'd0, m_busy});
    chk({tag, " rdata"}, host_rdata, m_rdata);
    chk({tag, " strobes"}, {5'd0, ev_host_wr, ev_host_rd, ev_drop}, {5'd0, m_evw, m_evr, m_evd});
  endtask

  task automatic cyc(logic [15:0] a, logic w, logic r, logic [7:0] wd,
                     logic lr, logic lw, logic [7:0] ld, logic sb, logic cb);
    host_addr = a; host_wr = w; host_rd = r; host_wdata = wd;
    loc_rd_in = lr; loc_wr_out = lw; loc_out_data = ld; loc_set_busy = sb; loc_clr_busy = cb;
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    cmp_all("R1");
    chk("R1 cmd-only in_full", {7'd0, c_in_full}, 8'd0);

    // R9: cmd-only channel drops data writes, accepts command writes
    cyc(DP, 1, 0, 8'h5A, 0, 0, 0, 0, 0);
    cmp_all("R2");
    chk("R9 drop in_full", {7'd0, c_in_full}, 8'd0);
    chk("R9 drop strobe", {7'd0, c_ev_drop}, 8'd1);
    chk("R9 byte kept", c_in_byte, 8'h00);
    cyc(CP, 1, 0, 8'hA7, 0, 0, 0, 0, 0);
    cmp_all("R2");
    chk("R9 cmd accepted", {c_in_full, c_is_cmd, 6'd0}, 8'hC0);
    chk("R9 cmd byte", c_in_byte, 8'hA7);

    // R6: status read, burst bit zero
    cyc(CP, 0, 1, 0, 0, 0, 0, 0, 0);
    cmp_all("R6");
    chk("R6 status", host_rdata, 8'h0A);

    // R3: local read clears in_full; same-cycle host write wins
    cyc(XP, 0, 0, 0, 1, 0, 0, 0, 0);
    cmp_all("R3");
    cyc(DP, 1, 0, 8'h33, 1, 0, 0, 0, 0);
    cmp_all("R3");
    chk("R3 write wins", {7'd0, loc_in_full}, 8'd1);

    // R4, R5: post byte, host takes it, collision
    cyc(XP, 0, 0, 0, 0, 1, 8'hC3, 0, 0);
    cmp_all("R4");
    cyc(DP, 0, 1, 0, 0, 0, 0, 0, 0);
    cmp_all("R5");
    chk("R5 data", host_rdata, 8'hC3);
    cyc(DP, 0, 1, 0, 0, 1, 8'h11, 0, 0);
    cmp_all("R5");
    chk("R5 local write wins", {7'd0, loc_out_full}, 8'd1);

    // R7, R8: busy, dropped command, data accepted while busy
    cyc(XP, 0, 0, 0, 0, 0, 0, 1, 1);
    cmp_all("R7");
    cyc(CP, 1, 0, 8'hEE, 0, 0, 0, 0, 0);
    cmp_all("R8");
    chk("R8 byte kept", loc_in_byte, 8'h33);
    cyc(DP, 1, 0, 8'h44, 0, 0, 0, 0, 0);
    cmp_all("R8");
    cyc(CP, 0, 1, 0, 0, 0, 0, 0, 1);
    cmp_all("R6");
    chk("R6 busy status", host_rdata, 8'h07);

    // R10: foreign address does nothing
    cyc(XP, 1, 1, 8'h99, 0, 0, 0, 0, 0);
    cmp_all("R10");

    // Random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] pick;
      logic [15:0] a;
      pick = 2'($urandom_range(0, 3));
      a = (pick == 0) ? DP : (pick == 1) ? CP : (pick == 2) ? XP : DP + 16'd4 + 16'd4;
      cyc(a, ($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0), 8'($urandom),
          ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0), 8'($urandom),
          ($urandom_range(0, 5) == 0), ($urandom_range(0, 4) == 0));
      cmp_all("RND R2/R3/R4/R5/R6/R7/R8/R10");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule